// File: doc/BRIEF.md
# Pin-Change Interrupt Latch

This block watches the synchronised input levels of several 8-bit I/O ports. It flags any level change on any pin, rising or falling, in a per-port status byte. Each flagged bit stays set until software reads that port's status byte. The read returns the flagged bits and clears them as it completes. A shared active-low interrupt line is asserted while at least one flagged bit belongs to a pin whose mask bit is 0.

Status bytes occupy consecutive register addresses starting at a base address, one per port. A bus front end that streams a multi-byte read from the base address therefore collects port 0, then port 1, and so on. The front end presents each byte access as one cycle with the read enable high and the byte address on the address input. The read data is valid in that same cycle, and the clear takes effect at the following clock edge.

Top module: `pin_change_irq`

## Requirements
- R1: A synchronous reset (rstN low at a clock edge) clears every status bit and holds intN high. The reset also records the pin levels present during reset, so a level held from reset into normal operation is not reported as a change.
- R2: A level change on pin b of port p, in either direction, sets status bit b of port p. Pin b of port p is pinLevel[p*8+b]. The change is detected at the clock edge where the new level is first sampled and is visible from the next cycle.
- R3: A set status bit stays set whatever the pin does afterwards, including a return to its old level, until its port's status is read.
- R4: With rdEn high and rdAddr equal to 0x10+p for a present port p, rdData shows port p's status byte in that cycle. That status is cleared at the next clock edge.
- R5: A pin change sampled at the same clock edge as the clearing read of its port stays set, and the next read returns it.
- R6: intN is low exactly when some set status bit has intMask bit 0 (intMask[p*8+b] belongs to pin b of port p). A mask bit of 1 keeps that bit from asserting intN, but the bit is still latched and readable.
- R7: When rdEn is low, or rdAddr is not 0x10+p for a present port (including 0x13 to 0x17 and addresses below 0x10), rdData is 0 and no status bit is cleared.
- R8: Reads at 0x10 and then 0x11 on consecutive cycles return port 0's status and then port 1's status, each intact.
- R9: Reading one port's status clears no bit of any other port.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| pinLevel | input | 24 | Synchronised pin levels, port p in bits p*8+7..p*8 |
| intMask | input | 24 | Per-pin interrupt mask, 1 suppresses the interrupt |
| rdEn | input | 1 | One-cycle status read strobe |
| rdAddr | input | 8 | Register address of the read |
| rdData | output | 8 | Status byte of the addressed port, 0 if no valid read |
| intN | output | 1 | Active-low interrupt, low while any unmasked status bit is set |

## Verification
The hardest case to reach is a pin edge that lands in exactly the cycle where its port's status is being read and cleared. Here the new bit has to survive the clear, while the bits the read returned have to go. The stimulus first latches one bit, then reads that port while flipping a different pin of the same port in the same cycle. A second read then shows that only the new bit remains. Pin pulses that return to their old level, and reset released with pins that differ from their pre-reset values, are also driven to show that latching and reset sampling hold.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;

  // Status window of the register map: up to 2**PORT_SEL_W ports.
  localparam int PORT_SEL_W = 3;
  localparam int WINDOW_PORTS = 1 << PORT_SEL_W;

  // Strobes sent from address decode to the status datapath.
  typedef struct packed {
    logic                  hit;   // valid status read this cycle
    logic [PORT_SEL_W-1:0] sel;   // port addressed by the read
  } strobe_t;

endpackage

// File: rtl/pin_change_irq_ctrl.sv
module pin_change_irq_ctrl
  import pin_change_irq_pkg::*;
#(
  parameter int                NUM_PORTS = 3,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] rdAddr,
  output strobe_t           ctl
);

  localparam logic [ADDR_W-1:0] PORTS_A = ADDR_W'(NUM_PORTS);

  logic [ADDR_W-1:0] offset;
  logic              inRange;

  always_comb begin
    offset  = rdAddr - BASE_ADDR;
    inRange = (rdAddr >= BASE_ADDR) && (offset < PORTS_A);
    ctl.hit = rdEn && inRange;
    ctl.sel = PORT_SEL_W'(offset);
  end

endmodule

// File: rtl/pin_change_irq_dp.sv
module pin_change_irq_dp
  import pin_change_irq_pkg::*;
#(
  parameter int NUM_PORTS = 3,
  parameter int PORT_W    = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic [NUM_PORTS*PORT_W-1:0]   pinLevel,
  input  logic [NUM_PORTS*PORT_W-1:0]   intMask,
  input  strobe_t                       ctl,
  output logic [PORT_W-1:0]             rdData,
  output logic                          intN
);

  localparam int TOTAL_W = NUM_PORTS * PORT_W;

  logic [TOTAL_W-1:0] prevQ;
  logic [TOTAL_W-1:0] statQ;
  logic [TOTAL_W-1:0] statNext;
  logic [TOTAL_W-1:0] pinChg;

  assign pinChg = pinLevel ^ prevQ;

  // Per port: clear on its own read, then merge new edges so they win.
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic clrPort;
    assign clrPort = ctl.hit && (ctl.sel == PORT_SEL_W'(p));
    assign statNext[p*PORT_W +: PORT_W] =
        (statQ[p*PORT_W +: PORT_W] & ~{PORT_W{clrPort}}) |
        pinChg[p*PORT_W +: PORT_W];
  end

  always_ff @(posedge clk) begin
    prevQ <= pinLevel;
    if (!rstN) begin
      statQ <= '0;
    end else begin
      statQ <= statNext;
    end
  end

  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (ctl.hit && (ctl.sel == PORT_SEL_W'(p))) begin
        rdData = statQ[p*PORT_W +: PORT_W];
      end
    end
  end

  assign intN = ~|(statQ & ~intMask);

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pin_change_irq_pkg::*;
#(
  parameter int                NUM_PORTS = 3,
  parameter int                PORT_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic [NUM_PORTS*PORT_W-1:0] pinLevel,
  input  logic [NUM_PORTS*PORT_W-1:0] intMask,
  input  logic                        rdEn,
  input  logic [ADDR_W-1:0]           rdAddr,
  output logic [PORT_W-1:0]           rdData,
  output logic                        intN
);

  strobe_t ctl;

  pin_change_irq_ctrl #(
    .NUM_PORTS(NUM_PORTS),
    .ADDR_W   (ADDR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_ctrl (
    .rdEn  (rdEn),
    .rdAddr(rdAddr),
    .ctl   (ctl)
  );

  pin_change_irq_dp #(
    .NUM_PORTS(NUM_PORTS),
    .PORT_W   (PORT_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .pinLevel(pinLevel),
    .intMask (intMask),
    .ctl     (ctl),
    .rdData  (rdData),
    .intN    (intN)
  );

endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int                NUM_PORTS = 3,
  parameter int                PORT_W    = 8,
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 8'h10
) (
  input logic                        clk,
  input logic                        rstN,
  input logic [NUM_PORTS*PORT_W-1:0] pinLevel,
  input logic [NUM_PORTS*PORT_W-1:0] intMask,
  input logic                        rdEn,
  input logic [ADDR_W-1:0]           rdAddr,
  input logic [PORT_W-1:0]           rdData,
  input logic                        intN
);

  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(NUM_PORTS - 1);

  logic validRead;
  assign validRead = rdEn && (rdAddr >= BASE_ADDR) && (rdAddr <= LAST_ADDR);

  // R1: the first cycle out of reset has no interrupt pending
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> intN);

  // R6: with every pin masked the line never asserts
  p_all_masked_r6: assert property (@(posedge clk) disable iff (!rstN)
    (&intMask) |-> intN);

  // R7: no valid read, no data
  p_idle_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    !validRead |-> (rdData == '0));

  // R2: an unmasked edge latched at the previous edge pulls intN low
  p_edge_flags_r2: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && (|(($past(pinLevel) ^ $past(pinLevel, 2)) & ~intMask)))
      |-> !intN);

  // R4: a second back-to-back read of a quiet port returns zero
  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    localparam logic [ADDR_W-1:0] PORT_ADDR = BASE_ADDR + ADDR_W'(p);
    p_read_clears_r4: assert property (@(posedge clk) disable iff (!rstN)
      (rdEn && (rdAddr == PORT_ADDR) && $past(rstN) && $past(rdEn) &&
       ($past(rdAddr) == PORT_ADDR) &&
       ($past(pinLevel[p*PORT_W +: PORT_W]) ==
        $past(pinLevel[p*PORT_W +: PORT_W], 2)))
        |-> (rdData == '0));
  end

endmodule

bind pin_change_irq pin_change_irq_chk #(
  .NUM_PORTS(NUM_PORTS),
  .PORT_W   (PORT_W),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .pinLevel(pinLevel),
  .intMask (intMask),
  .rdEn    (rdEn),
  .rdAddr  (rdAddr),
  .rdData  (rdData),
  .intN    (intN)
);

// File: tb/tb_pin_change_irq.sv
module tb_pin_change_irq;

  logic        clk = 1'b0;
  logic        rstN;
  logic [23:0] pinLevel;
  logic [23:0] intMask;
  logic        rdEn;
  logic [7:0]  rdAddr;
  logic [7:0]  rdData;
  logic        intN;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;   // 125 MHz

  pin_change_irq dut (
    .clk(clk), .rstN(rstN), .pinLevel(pinLevel), .intMask(intMask),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdData(rdData), .intN(intN)
  );

  // pin[24] mask[24] en[1] addr[8] expData[8] expIntN[1] req[4]
  localparam int NV = 36;
  localparam logic [69:0] VEC [NV] = '{
    {24'h00A53C, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd1},  // R1 no change at reset
    {24'h00A53C, 24'h000000, 1'b1, 8'h10, 8'h00, 1'b1, 4'd1},  // R1 status empty
    {24'h00A53D, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd2},  // R2 rise p0b0
    {24'h00A53D, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b0, 4'd2},  // R2 flagged
    {24'h00A43D, 24'h000000, 1'b1, 8'h10, 8'h01, 1'b0, 4'd4},  // R4 read p0, fall p1b0
    {24'h00A43D, 24'h000000, 1'b1, 8'h11, 8'h01, 1'b0, 4'd2},  // R2 falling edge seen
    {24'h00A43D, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd4},  // R4 all cleared
    {24'h81A43D, 24'hFF0000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd6},  // R6 p2 edges, masked
    {24'h81A43D, 24'hFF0000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd6},  // R6 masked no irq
    {24'h81A43D, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b0, 4'd6},  // R6 unmask -> irq
    {24'h81A43D, 24'h000000, 1'b1, 8'h12, 8'h81, 1'b0, 4'd4},  // R4 read p2
    {24'h81A43D, 24'h000000, 1'b1, 8'h12, 8'h00, 1'b1, 4'd4},  // R4 reread empty
    {24'h81A43F, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd2},  // R2 p0b1
    {24'h81A47F, 24'h000000, 1'b1, 8'h10, 8'h02, 1'b0, 4'd5},  // R5 read + new edge b6
    {24'h81A47F, 24'h000000, 1'b1, 8'h10, 8'h40, 1'b0, 4'd5},  // R5 b6 survived
    {24'h81A47F, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd5},
    {24'h81A67F, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd3},  // R3 p1b1 up
    {24'h81A47F, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b0, 4'd3},  // R3 back down
    {24'h81A47F, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b0, 4'd3},  // R3 still set
    {24'h81A47F, 24'h000000, 1'b1, 8'h11, 8'h02, 1'b0, 4'd3},
    {24'h81A47F, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd3},
    {24'h80A47E, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd7},  // R7 p0b0 and p2b0
    {24'h80A47E, 24'h000000, 1'b1, 8'h13, 8'h00, 1'b0, 4'd7},  // R7 empty slot
    {24'h80A47E, 24'h000000, 1'b0, 8'h10, 8'h00, 1'b0, 4'd7},  // R7 no strobe
    {24'h80A47E, 24'h000000, 1'b1, 8'h0F, 8'h00, 1'b0, 4'd7},  // R7 below window
    {24'h80A47E, 24'h000000, 1'b1, 8'h10, 8'h01, 1'b0, 4'd7},  // R7 nothing was cleared
    {24'h80A47E, 24'h000000, 1'b1, 8'h12, 8'h01, 1'b0, 4'd9},  // R9 p2 intact
    {24'h80A47E, 24'h000000, 1'b1, 8'h10, 8'h00, 1'b1, 4'd9},
    {24'h80247A, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd8},  // R8 p0b2, p1b7
    {24'h80247A, 24'h000000, 1'b1, 8'h10, 8'h04, 1'b0, 4'd8},  // R8 first byte
    {24'h80247A, 24'h000000, 1'b1, 8'h11, 8'h80, 1'b0, 4'd8},  // R8 second byte
    {24'h80247A, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd8},
    {24'h80247B, 24'h0000FF, 1'b0, 8'h00, 8'h00, 1'b1, 4'd6},  // R6 masked edge
    {24'h80247B, 24'h0000FF, 1'b0, 8'h00, 8'h00, 1'b1, 4'd6},
    {24'h80247B, 24'h0000FF, 1'b1, 8'h10, 8'h01, 1'b1, 4'd6},  // R6 still latched
    {24'h80247B, 24'h000000, 1'b0, 8'h00, 8'h00, 1'b1, 4'd6}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  task automatic readChk(input logic [7:0] addr, input logic [7:0] exp,
                         input string req);
    @(negedge clk);
    rdEn = 1'b1; rdAddr = addr;
    #1;
    check(req, "rdData", 32'(rdData), 32'(exp));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; pinLevel = 24'h00A53C; intMask = '0; rdEn = 1'b0; rdAddr = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "intN in reset", 32'(intN), 32'd1);
    check("R1", "rdData in reset", 32'(rdData), 32'd0);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      pinLevel = VEC[i][69:46];
      intMask  = VEC[i][45:22];
      rdEn     = VEC[i][21];
      rdAddr   = VEC[i][20:13];
      #1;
      check($sformatf("R%0d row%0d", VEC[i][3:0], i), "rdData",
            32'(rdData), 32'(VEC[i][12:5]));
      check($sformatf("R%0d row%0d", VEC[i][3:0], i), "intN",
            32'(intN), 32'(VEC[i][4]));
    end

    // R3: pin toggling repeatedly leaves one latched bit
    @(negedge clk); rdEn = 1'b0; pinLevel = 24'h00247B;
    @(negedge clk); pinLevel = 24'h80247B;
    @(negedge clk); pinLevel = 24'h00247B;
    @(negedge clk); pinLevel = 24'h80247B;
    @(negedge clk); #1;
    check("R3", "intN after toggles", 32'(intN), 32'd0);
    readChk(8'h12, 8'h80, "R3");
    readChk(8'h12, 8'h00, "R4");

    // R1: reset mid-run with a pending bit and changing pins
    @(negedge clk); rdEn = 1'b0; pinLevel = 24'h802C7B;
    @(negedge clk); rstN = 1'b0; pinLevel = 24'h123456;
    @(negedge clk); pinLevel = 24'h654321;
    @(negedge clk); rstN = 1'b1;
    #1;
    check("R1", "intN after reset", 32'(intN), 32'd1);
    @(negedge clk); #1;
    check("R1", "intN no edge reported", 32'(intN), 32'd1);
    readChk(8'h10, 8'h00, "R1");
    readChk(8'h11, 8'h00, "R1");
    readChk(8'h12, 8'h00, "R1");
    @(negedge clk); rdEn = 1'b0;
    @(negedge clk);
    finishRun();
  end

endmodule